// File: doc/BRIEF.md
# Device Wake-Request and Access Gate

This block owns the host-visible general control word that decides when the host may reach internal resources that can be powered down. The host writes two request bits into the control word. One bit marks initialisation complete and the other asks for the internal clock domain to stay awake. A four-state power machine (off, waking, awake, sleeping) reacts to those bits. It reports clock-ready and going-to-sleep status. It also drives an access-grant line that the indirect-access logic uses before it touches powered-down space.

The block also holds a mailbox word shared between the host and an internal controller. The host can load the mailbox whole, or it can set or clear individual bits through two companion addresses. The internal side sets and clears bits with its own per-bit strobes. Two status fields come from outside the block and are shown in the control word: the power-save type and the level of an external radio-kill switch. Clock gating and analog power sequencing are reduced to a single activity input (`busy_in`) and fixed wake and sleep durations.

Top module: `pwr_access_gate`

## Requirements
- R1: After synchronous reset (rst_n low), the control register holds zero. `clk_ready`, `going_sleep`, `access_grant`, `mbox_q` and `bus_rdata` are all 0.
- R2: The control register is at offset 0x0. `clk_ready` (control bit 0) stays 0 until init-done (bit 2) and access-request (bit 3) are both 1. If the write that sets both lands on clock edge e, `clk_ready` is 1 after edge e+1+WAKE_CYC and not before.
- R3: `access_grant` is 1 exactly when `clk_ready` is 1, `going_sleep` is 0 and access-request is 1.
- R4: From the awake state, access-request at 0 with `busy_in` at 0 starts sleeping. `going_sleep` (control bit 4) is then 1 for SLEEP_CYC cycles while `clk_ready` stays 1. After that, both fall together.
- R5: While awake, `busy_in` at 1 holds the device awake even with access-request at 0.
- R6: Clearing init-done returns the device to the off state, whatever the value of `busy_in`. From awake, this passes through the sleeping period. During waking, it aborts at once. With init-done at 0, `clk_ready` never rises.
- R7: A control read returns: bit 0 clock-ready, bit 2 init-done, bit 3 access-request, bit 4 going-to-sleep, bits 26:24 `ps_type_in`, bit 27 `rfkill_in`. All other bits read 0. Writes change only bits 2 and 3.
- R8: The mailbox is at 0x4, its set address at 0x8 and its clear address at 0xC. A write to 0x4 loads the word. A 1 written to 0x8 sets that bit, and a 1 written to 0xC clears that bit. A 0 written to 0x8 or 0xC changes nothing.
- R9: `int_set`/`int_clr` set and clear mailbox bits from the internal side in the same cycle as host writes. In any cycle, a clear from either side wins over a set or load of the same bit.
- R10: Reads are registered. `bus_rdata` updates on the edge where `bus_rd` is 1 and holds otherwise. Reads of 0x8, 0xC and any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe, data appears next cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy_in | input | 1 | Internal activity, holds the device awake |
| ps_type_in | input | 3 | Power-save type reported in bits 26:24 |
| rfkill_in | input | 1 | External radio-kill switch level |
| int_set | input | MBOX_W | Internal-side mailbox bit set strobes |
| int_clr | input | MBOX_W | Internal-side mailbox bit clear strobes |
| clk_ready | output | 1 | Internal clock domain is up |
| going_sleep | output | 1 | Power-down in progress |
| access_grant | output | 1 | Internal access permitted |
| mbox_q | output | MBOX_W | Current mailbox value |

## Verification
The bench builds the block with WAKE_CYC=3, SLEEP_CYC=2 and the default 32-bit mailbox and 8-bit address. The short durations make every waking and sleeping window only a few cycles long. This lets the bench compare each window edge against its model within a short run. It also lets it drop init-done in the middle of the waking window to check the abort path. The full mailbox width means every bit of the write data takes part in the load, set and clear tests.

// File: rtl/pg_pkg.sv
// Shared types and register layout for the wake-request and access gate.
// Assumes byte offsets on a 32-bit register bus.
package pg_pkg;
    typedef enum logic [1:0] {
        PS_OFF      = 2'd0,
        PS_WAKING   = 2'd1,
        PS_AWAKE    = 2'd2,
        PS_SLEEPING = 2'd3
    } pwr_state_e;

    localparam int OFF_CTRL = 'h0;
    localparam int OFF_MBOX = 'h4;
    localparam int OFF_MSET = 'h8;
    localparam int OFF_MCLR = 'hC;

    localparam int CB_READY   = 0;
    localparam int CB_INIT    = 2;
    localparam int CB_REQ     = 3;
    localparam int CB_GOSLEEP = 4;
    localparam int CB_PS_LO   = 24;
    localparam int CB_RFKILL  = 27;
endpackage

// File: rtl/pg_power_fsm.sv
// Power state machine: off -> waking -> awake -> sleeping -> off.
// Waking lasts WAKE_CYC cycles and sleeping lasts SLEEP_CYC cycles (both >= 1).
// Inputs come from registers, so there is no combinational path from the bus.
module pg_power_fsm
    import pg_pkg::*;
#(
    parameter int WAKE_CYC  = 4,
    parameter int SLEEP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_q,
    input  logic req_q,
    input  logic busy_in,
    output logic clk_ready,
    output logic going_sleep
);
    localparam int CNT_MAX = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    pwr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and window counter selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_OFF: if (init_q && req_q) begin
                state_d = PS_WAKING;
                cnt_d   = CNT_W'(WAKE_CYC - 1);
            end
            PS_WAKING: begin
                if (!init_q)              state_d = PS_OFF;
                else if (cnt_q == '0)     state_d = PS_AWAKE;
                else                      cnt_d   = cnt_q - 1'b1;
            end
            PS_AWAKE: if (!init_q || (!req_q && !busy_in)) begin
                state_d = PS_SLEEPING;
                cnt_d   = CNT_W'(SLEEP_CYC - 1);
            end
            PS_SLEEPING: begin
                if (cnt_q == '0) state_d = PS_OFF;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = PS_OFF;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign clk_ready   = (state_q == PS_AWAKE) || (state_q == PS_SLEEPING);
    assign going_sleep = (state_q == PS_SLEEPING);
endmodule

// File: rtl/pg_mailbox.sv
// Shared mailbox word with per-bit load, set and clear from two sides.
// Assumes the strobes are one-cycle pulses; a clear beats a set or load.
module pg_mailbox #(
    parameter int MBOX_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [MBOX_W-1:0] load_val,
    input  logic [MBOX_W-1:0] set_v,
    input  logic [MBOX_W-1:0] clr_v,
    output logic [MBOX_W-1:0] mbox_q
);
    for (genvar b = 0; b < MBOX_W; b++) begin : g_bit
        logic nxt;
        // Per-bit next value: load, then set, then clear.
        always_comb begin
            nxt = load_en ? load_val[b] : mbox_q[b];
            nxt = (nxt | set_v[b]) & ~clr_v[b];
        end
        // Per-bit storage.
        always_ff @(posedge clk) begin
            if (!rst_n) mbox_q[b] <= 1'b0;
            else        mbox_q[b] <= nxt;
        end
    end
endmodule

// File: rtl/pg_regif.sv
// Register decoder: control request bits, mailbox host strobes, registered read.
// Assumes aligned byte offsets; unmapped offsets read zero.
module pg_regif
    import pg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int MBOX_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              clk_ready,
    input  logic              going_sleep,
    input  logic [2:0]        ps_type_in,
    input  logic              rfkill_in,
    input  logic [MBOX_W-1:0] mbox_q,
    output logic              init_q,
    output logic              req_q,
    output logic              mb_load,
    output logic [MBOX_W-1:0] mb_set,
    output logic [MBOX_W-1:0] mb_clr
);
    logic        hit_ctrl, hit_mbox, hit_mset, hit_mclr;
    logic [31:0] ctrl_word, rd_next;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_mbox = (bus_addr == ADDR_W'(OFF_MBOX));
    assign hit_mset = (bus_addr == ADDR_W'(OFF_MSET));
    assign hit_mclr = (bus_addr == ADDR_W'(OFF_MCLR));

    assign mb_load = bus_wr && hit_mbox;
    assign mb_set  = (bus_wr && hit_mset) ? bus_wdata[MBOX_W-1:0] : '0;
    assign mb_clr  = (bus_wr && hit_mclr) ? bus_wdata[MBOX_W-1:0] : '0;

    // Host request bits, written only through the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            req_q  <= 1'b0;
        end else if (bus_wr && hit_ctrl) begin
            init_q <= bus_wdata[CB_INIT];
            req_q  <= bus_wdata[CB_REQ];
        end
    end

    // Assemble the control word from live status.
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[CB_READY]              = clk_ready;
        ctrl_word[CB_INIT]               = init_q;
        ctrl_word[CB_REQ]                = req_q;
        ctrl_word[CB_GOSLEEP]            = going_sleep;
        ctrl_word[CB_PS_LO+2:CB_PS_LO]   = ps_type_in;
        ctrl_word[CB_RFKILL]             = rfkill_in;
    end

    // Read multiplexer.
    always_comb begin
        if (hit_ctrl)      rd_next = ctrl_word;
        else if (hit_mbox) rd_next = 32'(mbox_q);
        else               rd_next = '0;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/pwr_access_gate.sv
// Top of the wake-request and access gate: control register, power state
// machine, access grant and the host/internal mailbox.
// Assumes all inputs are synchronous to clk.
module pwr_access_gate #(
    parameter int ADDR_W    = 8,
    parameter int MBOX_W    = 32,
    parameter int WAKE_CYC  = 4,
    parameter int SLEEP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy_in,
    input  logic [2:0]        ps_type_in,
    input  logic              rfkill_in,
    input  logic [MBOX_W-1:0] int_set,
    input  logic [MBOX_W-1:0] int_clr,
    output logic              clk_ready,
    output logic              going_sleep,
    output logic              access_grant,
    output logic [MBOX_W-1:0] mbox_q
);
    logic              init_q, req_q, mb_load;
    logic [MBOX_W-1:0] mb_set, mb_clr;

    pg_regif #(.ADDR_W(ADDR_W), .MBOX_W(MBOX_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_ready(clk_ready), .going_sleep(going_sleep),
        .ps_type_in(ps_type_in), .rfkill_in(rfkill_in), .mbox_q(mbox_q),
        .init_q(init_q), .req_q(req_q),
        .mb_load(mb_load), .mb_set(mb_set), .mb_clr(mb_clr)
    );

    pg_power_fsm #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .init_q(init_q), .req_q(req_q), .busy_in(busy_in),
        .clk_ready(clk_ready), .going_sleep(going_sleep)
    );

    pg_mailbox #(.MBOX_W(MBOX_W)) u_mbox (
        .clk(clk), .rst_n(rst_n),
        .load_en(mb_load), .load_val(bus_wdata[MBOX_W-1:0]),
        .set_v(mb_set | int_set), .clr_v(mb_clr | int_clr),
        .mbox_q(mbox_q)
    );

    // Grant only while the domain is up, not winding down, and still requested.
    assign access_grant = clk_ready && !going_sleep && req_q;
endmodule

// File: rtl/pg_checker.sv
// Temporal checks on the access gate, attached by bind.
module pg_checker #(
    parameter int ADDR_W = 8,
    parameter int MBOX_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy_in,
    input logic [MBOX_W-1:0] int_clr,
    input logic              init_q,
    input logic              clk_ready,
    input logic              going_sleep,
    input logic              access_grant,
    input logic [MBOX_W-1:0] mbox_q
);
    a_r4_sleep_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        going_sleep |-> clk_ready);

    a_r4_ready_falls_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_ready) |-> $past(going_sleep));

    a_r3_no_grant_sleeping: assert property (@(posedge clk) disable iff (!rst_n)
        going_sleep |-> !access_grant);

    a_r6_no_wake_without_init: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_q && !clk_ready) |=> !clk_ready);

    a_r5_busy_holds_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && !going_sleep && busy_in && init_q) |=> !going_sleep);

    a_r8_set_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h8) && int_clr == '0)
        |=> ((mbox_q & $past(bus_wdata[MBOX_W-1:0])) == $past(bus_wdata[MBOX_W-1:0])));

    a_r8_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('hC))
        |=> ((mbox_q & $past(bus_wdata[MBOX_W-1:0])) == '0));
endmodule

bind pwr_access_gate pg_checker #(.ADDR_W(ADDR_W), .MBOX_W(MBOX_W)) u_pg_checker (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy_in(busy_in), .int_clr(int_clr),
    .init_q(init_q), .clk_ready(clk_ready), .going_sleep(going_sleep),
    .access_grant(access_grant), .mbox_q(mbox_q)
);

// File: tb/pwr_access_gate_test.sv
module pwr_access_gate_test;
    localparam int AW = 8;
    localparam int MW = 32;
    localparam int WK = 3;
    localparam int SL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          busy_in = 1'b0;
    logic [2:0]    ps_type_in = 3'b010;
    logic          rfkill_in = 1'b1;
    logic [MW-1:0] int_set = '0, int_clr = '0;
    logic          clk_ready, going_sleep, access_grant;
    logic [MW-1:0] mbox_q;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_access_gate #(.ADDR_W(AW), .MBOX_W(MW), .WAKE_CYC(WK), .SLEEP_CYC(SL)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy_in(busy_in), .ps_type_in(ps_type_in), .rfkill_in(rfkill_in),
        .int_set(int_set), .int_clr(int_clr), .clk_ready(clk_ready),
        .going_sleep(going_sleep), .access_grant(access_grant), .mbox_q(mbox_q)
    );

    // Behavioural reference model: 0 off, 1 waking, 2 awake, 3 sleeping.
    int          m_st = 0, m_cnt = 0;
    bit          m_init = 0, m_req = 0;
    logic [31:0] m_mbox = '0, m_rdata = '0;

    function automatic bit m_ready();
        return (m_st == 2) || (m_st == 3);
    endfunction

    always @(posedge clk) begin
        int          st, cnt;
        bit          ni, nr;
        logic [31:0] mb, rw;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_init = 0; m_req = 0; m_mbox = '0; m_rdata = '0;
        end else begin
            st = m_st; cnt = m_cnt; ni = m_init; nr = m_req;
            if (bus_wr && bus_addr == 8'h0) begin ni = bus_wdata[2]; nr = bus_wdata[3]; end
            if (m_st == 0) begin
                if (m_init && m_req) begin st = 1; cnt = WK - 1; end
            end else if (m_st == 1) begin
                if (!m_init) st = 0;
                else if (m_cnt == 0) st = 2;
                else cnt = m_cnt - 1;
            end else if (m_st == 2) begin
                if (!m_init || (!m_req && !busy_in)) begin st = 3; cnt = SL - 1; end
            end else begin
                if (m_cnt == 0) st = 0; else cnt = m_cnt - 1;
            end
            rw = m_rdata;
            if (bus_rd) begin
                if (bus_addr == 8'h0)
                    rw = {4'b0, rfkill_in, ps_type_in, 19'b0, (m_st == 3), m_req, m_init, 1'b0, m_ready()};
                else if (bus_addr == 8'h4) rw = m_mbox;
                else rw = '0;
            end
            mb = (bus_wr && bus_addr == 8'h4) ? bus_wdata : m_mbox;
            mb = mb | ((bus_wr && bus_addr == 8'h8) ? bus_wdata : 32'h0) | int_set;
            mb = mb & ~(((bus_wr && bus_addr == 8'hC) ? bus_wdata : 32'h0) | int_clr);
            m_st = st; m_cnt = cnt; m_init = ni; m_req = nr; m_mbox = mb; m_rdata = rw;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 clk_ready", 32'(clk_ready), 32'(m_ready()));
            chk("R4 going_sleep", 32'(going_sleep), 32'(m_st == 3));
            chk("R3 access_grant", 32'(access_grant), 32'(m_ready() && m_st != 3 && m_req));
            chk("R8 mbox", mbox_q, m_mbox);
            chk("R10 rdata", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 ready", 32'(clk_ready), 0);
        chk("R1 grant", 32'(access_grant), 0);
        chk("R1 mbox", mbox_q, 0);
        chk("R1 rdata", bus_rdata, 0);

        // R2: init-done alone does not wake
        wr(8'h0, 32'h4);
        idle(10);
        chk("R2 init only", 32'(clk_ready), 0);
        // R2: init plus request wakes after WK+1 edges
        wr(8'h0, 32'hC);
        idle(WK);
        chk("R2 still waking", 32'(clk_ready), 0);
        idle(1);
        chk("R2 ready", 32'(clk_ready), 1);
        chk("R3 grant", 32'(access_grant), 1);

        // R7: control read layout, and read-only bits ignore writes
        rd(8'h0);
        chk("R7 ctrl read", bus_rdata, 32'h0A00000D);
        wr(8'h0, 32'hFFFF_FFFF);
        rfkill_in = 1'b0; ps_type_in = 3'b011;
        rd(8'h0);
        chk("R7 ro bits", bus_rdata, 32'h0300000D);
        idle(2);
        chk("R10 rdata holds", bus_rdata, 32'h0300000D);

        // R5: busy holds awake with request cleared
        busy_in = 1'b1;
        wr(8'h0, 32'h4);
        idle(8);
        chk("R5 held awake", 32'(clk_ready), 1);
        chk("R5 not sleeping", 32'(going_sleep), 0);
        chk("R3 no grant w/o req", 32'(access_grant), 0);
        // R4: sleeping window once idle
        busy_in = 1'b0;
        idle(1);
        chk("R4 sleep start", 32'(going_sleep), 1);
        chk("R4 ready held", 32'(clk_ready), 1);
        idle(SL - 1);
        chk("R4 sleep end", 32'(going_sleep), 1);
        idle(1);
        chk("R4 off", 32'(clk_ready), 0);

        // R6: clearing init from awake sleeps despite busy
        wr(8'h0, 32'hC);
        idle(WK + 2);
        busy_in = 1'b1;
        wr(8'h0, 32'h8);
        idle(SL + 2);
        chk("R6 off after init clear", 32'(clk_ready), 0);
        idle(10);
        chk("R6 stays off", 32'(clk_ready), 0);
        busy_in = 1'b0;
        // R6: abort during waking
        wr(8'h0, 32'hC);
        idle(1);
        wr(8'h0, 32'h8);
        idle(WK + 4);
        chk("R6 wake aborted", 32'(clk_ready), 0);

        // R8: mailbox load, set, clear, zero writes
        wr(8'h4, 32'h0000_00A5);
        wr(8'h8, 32'h0000_000F);
        chk("R8 set", mbox_q, 32'hAF);
        wr(8'hC, 32'h0000_00A0);
        chk("R8 clr", mbox_q, 32'h0F);
        wr(8'h8, 32'h0);
        wr(8'hC, 32'h0);
        chk("R8 zero no effect", mbox_q, 32'h0F);
        rd(8'h4);
        chk("R8 mbox read", bus_rdata, 32'h0F);

        // R9: internal strobes, clear wins over host set
        int_set = 32'h100; int_clr = 32'h1;
        wr(8'h8, 32'h1);
        int_set = '0; int_clr = '0;
        chk("R9 clear wins", mbox_q, 32'h10E);
        int_set = 32'h8000_0000;
        idle(1);
        int_set = '0;
        chk("R9 internal set", mbox_q, 32'h8000_010E);

        // R10: set/clear/unmapped offsets read zero
        rd(8'h8);
        chk("R10 set addr read", bus_rdata, 0);
        rd(8'h4);
        rd(8'h40);
        chk("R10 unmapped read", bus_rdata, 0);

        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule